// File: doc/BRIEF.md
# I2C Transfer Watchdog and Bus Recovery

This block sits beside an I2C master and guards every byte-level operation that master performs. While an operation is outstanding it counts clock cycles. If the master does not report completion within a bounded number of cycles, the operation has failed. A completed address or data byte that the slave did not acknowledge also counts as a failure. The block does not take part in normal data transfer. It only observes the handshake and the acknowledge status.

On a failure it lights an error indicator and holds the master disabled with its configuration cleared. It then takes ownership of SCL and clocks the bus to free a slave that is holding SDA low. Each clock starts with SCL low, then SCL goes high and SDA is sampled at the end of the high phase. Clocking stops as soon as SDA reads high, and never runs for more than a fixed number of pulses. After that, SCL is released and a fixed settling delay runs. The master is then re-enabled with the fast-mode clock divisor, the indicator is cleared, and a one-cycle done pulse tells the caller to abort or retry its transaction.

Top module: `i2c_recover`

## Requirements
- R1: After reset, scl_oe=0, scl_o=1, err_led=0, mst_rst=0, rec_done=0 and mst_div=DIV_VAL.
- R2: While watching, a failure is detected at the clock edge where op_pend has been sampled high with op_done low on TIMEOUT_MAX consecutive edges. The count restarts whenever an edge samples op_pend low or op_done high.
- R3: While watching, an edge that samples op_pend, op_done, op_ackchk and op_nack all high is a failure. When op_ackchk is low, op_nack has no effect. When op_done and the last allowed timeout edge coincide, the completion wins.
- R4: One cycle after a failure edge, err_led=1, mst_rst=1, mst_div=0, scl_oe=1 and scl_o=0. While scl_oe is high, mst_rst and err_led stay high.
- R5: During recovery, SCL is driven low for PHASE_CYC cycles and then high for PHASE_CYC cycles. sda_i is sampled at the edge that ends each high phase. If it reads 1, clocking stops with SCL left high.
- R6: At most MAX_PULSES high phases are issued per recovery, even if SDA stays low.
- R7: The edge after clocking stops releases SCL (scl_oe=0). SETTLE_CYC edges later, mst_rst=0, mst_div=DIV_VAL and err_led=0 are applied, and rec_done is high for exactly one cycle.
- R8: The op_* inputs have no effect from the failure edge until rec_done. The timeout count starts afresh when watching resumes.
- R9: While op_pend stays high, each op_done ends one operation and restarts the count, so a chain of operations each shorter than the limit never fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_pend | input | 1 | A byte operation of the master is outstanding |
| op_done | input | 1 | The master reports the current operation complete |
| op_ackchk | input | 1 | The operation was an address or data byte whose acknowledge is checked |
| op_nack | input | 1 | Acknowledge status at completion, 1 = not acknowledged |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 = this block owns SCL |
| scl_o | output | 1 | SCL level driven while scl_oe is 1 |
| mst_rst | output | 1 | Holds the master disabled with its state cleared |
| mst_div | output | DIV_W | Bus clock divisor handed to the master, 0 while disabled |
| err_led | output | 1 | Error indicator |
| rec_done | output | 1 | One-cycle pulse when the master has been re-enabled |

## Verification
The timeout and the completion can fall on the same edge. An operation whose op_done arrives exactly on the edge where the count would expire must complete cleanly, and with op_ackchk and op_nack also set it must fail through the acknowledge path instead. The bench provokes this by holding op_pend for TIMEOUT_MAX-1 waiting edges and placing op_done on the next one. A behavioural model compares all outputs on every cycle to judge the result. The two stop causes of the bus clear can also coincide: SDA rising on the final allowed pulse. The bench judges this by counting SCL rising edges while the block owns the line.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;
  typedef enum logic [1:0] {CTL_WATCH, CTL_CLEAR, CTL_SETTLE} ctl_state_t;
  typedef enum logic [1:0] {CLK_IDLE, CLK_LOW, CLK_HIGH} clk_phase_t;
endpackage

// File: rtl/i2c_op_guard.sv
module i2c_op_guard #(
  parameter int TIMEOUT_MAX = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic op_pend,
  input  logic op_done,
  input  logic op_ackchk,
  input  logic op_nack,
  output logic fail_o
);
  localparam int TW = $clog2(TIMEOUT_MAX + 1);

  logic [TW-1:0] wcnt;
  logic          expired;
  logic          nacked;

  always_comb begin
    expired = (wcnt == TW'(1));
    nacked  = op_ackchk & op_nack;
    // completion on the last allowed edge takes precedence over expiry
    fail_o  = arm & op_pend & (op_done ? nacked : expired);
  end

  // down-counter reloads whenever no operation is waiting
  always_ff @(posedge clk) begin
    if (rst || !arm || !op_pend || op_done)
      wcnt <= TW'(TIMEOUT_MAX);
    else
      wcnt <= wcnt - 1'b1;
  end
endmodule

// File: rtl/i2c_scl_clear.sv
module i2c_scl_clear
  import i2c_rcv_pkg::*;
#(
  parameter int PHASE_CYC  = 80,
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic sda_i,
  output logic scl_o,
  output logic done_o
);
  localparam int PW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam int NW = $clog2(MAX_PULSES + 1);

  clk_phase_t    ph;
  logic [PW-1:0] pcnt;
  logic [NW-1:0] npul;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= CLK_IDLE;
      pcnt   <= '0;
      npul   <= '0;
      scl_o  <= 1'b1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (ph)
        CLK_IDLE: if (start) begin
          ph    <= CLK_LOW;
          pcnt  <= PW'(PHASE_CYC - 1);
          npul  <= '0;
          scl_o <= 1'b0;
        end
        CLK_LOW: if (pcnt == '0) begin
          ph    <= CLK_HIGH;
          pcnt  <= PW'(PHASE_CYC - 1);
          scl_o <= 1'b1;
        end else begin
          pcnt <= pcnt - 1'b1;
        end
        CLK_HIGH: if (pcnt == '0) begin
          npul <= npul + 1'b1;
          if (sda_i || npul == NW'(MAX_PULSES - 1)) begin
            ph     <= CLK_IDLE;
            done_o <= 1'b1;
          end else begin
            ph    <= CLK_LOW;
            pcnt  <= PW'(PHASE_CYC - 1);
            scl_o <= 1'b0;
          end
        end else begin
          pcnt <= pcnt - 1'b1;
        end
        default: ph <= CLK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_recover.sv
module i2c_recover
  import i2c_rcv_pkg::*;
#(
  parameter int TIMEOUT_MAX = 256,
  parameter int PHASE_CYC   = 80,
  parameter int MAX_PULSES  = 9,
  parameter int SETTLE_CYC  = 160000,
  parameter int DIV_W       = 8,
  parameter int DIV_VAL     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_pend,
  input  logic             op_done,
  input  logic             op_ackchk,
  input  logic             op_nack,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             scl_o,
  output logic             mst_rst,
  output logic [DIV_W-1:0] mst_div,
  output logic             err_led,
  output logic             rec_done
);
  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  ctl_state_t    st;
  logic [SW-1:0] scnt;
  logic          fail;
  logic          clr_start;
  logic          clr_done;

  i2c_op_guard #(.TIMEOUT_MAX(TIMEOUT_MAX)) u_guard (
    .clk(clk), .rst(rst), .arm(st == CTL_WATCH),
    .op_pend(op_pend), .op_done(op_done),
    .op_ackchk(op_ackchk), .op_nack(op_nack),
    .fail_o(fail)
  );

  assign clr_start = fail && (st == CTL_WATCH);

  i2c_scl_clear #(.PHASE_CYC(PHASE_CYC), .MAX_PULSES(MAX_PULSES)) u_clear (
    .clk(clk), .rst(rst), .start(clr_start), .sda_i(sda_i),
    .scl_o(scl_o), .done_o(clr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= CTL_WATCH;
      scnt     <= '0;
      scl_oe   <= 1'b0;
      mst_rst  <= 1'b0;
      mst_div  <= DIV_W'(DIV_VAL);
      err_led  <= 1'b0;
      rec_done <= 1'b0;
    end else begin
      rec_done <= 1'b0;
      case (st)
        CTL_WATCH: if (clr_start) begin
          st      <= CTL_CLEAR;
          scl_oe  <= 1'b1;
          mst_rst <= 1'b1;
          mst_div <= '0;
          err_led <= 1'b1;
        end
        CTL_CLEAR: if (clr_done) begin
          st     <= CTL_SETTLE;
          scl_oe <= 1'b0;
          scnt   <= SW'(SETTLE_CYC - 1);
        end
        CTL_SETTLE: if (scnt == '0) begin
          st       <= CTL_WATCH;
          mst_rst  <= 1'b0;
          mst_div  <= DIV_W'(DIV_VAL);
          err_led  <= 1'b0;
          rec_done <= 1'b1;
        end else begin
          scnt <= scnt - 1'b1;
        end
        default: st <= CTL_WATCH;
      endcase
    end
  end
endmodule

// File: rtl/i2c_recover_chk.sv
module i2c_recover_chk #(
  parameter int MAX_PULSES = 9,
  parameter int DIV_W      = 8,
  parameter int DIV_VAL    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_oe,
  input logic             scl_o,
  input logic             mst_rst,
  input logic [DIV_W-1:0] mst_div,
  input logic             err_led,
  input logic             rec_done
);
  localparam int CW = $clog2(MAX_PULSES + 2);

  logic [CW-1:0] rises;
  logic          scl_q;

  always_ff @(posedge clk) begin
    scl_q <= scl_o;
    if (rst || !scl_oe) rises <= '0;
    else if (scl_o && !scl_q) rises <= rises + 1'b1;
  end

  p_owned_r4: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> (mst_rst && err_led));

  p_start_low_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> !scl_o);

  p_div_off_r4: assert property (@(posedge clk) disable iff (rst)
    mst_rst |-> (mst_div == '0));

  p_pulse_cap_r6: assert property (@(posedge clk) disable iff (rst)
    rises <= CW'(MAX_PULSES));

  p_release_high_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_oe) |-> scl_o);

  p_reinit_r7: assert property (@(posedge clk) disable iff (rst)
    rec_done |-> (!err_led && !mst_rst && mst_div == DIV_W'(DIV_VAL)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    rec_done |=> !rec_done);
endmodule

bind i2c_recover i2c_recover_chk #(
  .MAX_PULSES(MAX_PULSES), .DIV_W(DIV_W), .DIV_VAL(DIV_VAL)
) u_chk (
  .clk(clk), .rst(rst), .scl_oe(scl_oe), .scl_o(scl_o),
  .mst_rst(mst_rst), .mst_div(mst_div), .err_led(err_led), .rec_done(rec_done)
);

// File: tb/i2c_recover_tb.sv
module i2c_recover_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T  = 16;
  localparam int PH = 3;
  localparam int MP = 9;
  localparam int ST = 10;
  localparam int DW = 8;
  localparam int DV = 8;

  logic clk = 0, rst = 1;
  logic op_pend = 0, op_done = 0, op_ackchk = 0, op_nack = 0, sda_i = 1;
  logic scl_oe, scl_o, mst_rst, err_led, rec_done;
  logic [DW-1:0] mst_div;

  i2c_recover #(.TIMEOUT_MAX(T), .PHASE_CYC(PH), .MAX_PULSES(MP),
                .SETTLE_CYC(ST), .DIV_W(DW), .DIV_VAL(DV)) u_dut (
    .clk(clk), .rst(rst), .op_pend(op_pend), .op_done(op_done),
    .op_ackchk(op_ackchk), .op_nack(op_nack), .sda_i(sda_i),
    .scl_oe(scl_oe), .scl_o(scl_o), .mst_rst(mst_rst), .mst_div(mst_div),
    .err_led(err_led), .rec_done(rec_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  string tag = "R1";

  task automatic chk(string t, string nm, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %0d exp %0d", t, nm, got, exp);
    end
  endtask

  // behavioural reference: mode 0 watch, 1 clocking, 3 release, 2 settle
  int m_mode = 0, m_wait = 0, m_ticks = 0, m_pulses = 0, m_settle = 0, m_div = DV;
  bit m_oe = 0, m_scl = 1, m_mrst = 0, m_led = 0, m_done = 0, m_started = 0, m_fail = 0;

  always @(posedge clk) begin
    m_started = 1;
    m_done = 0;
    if (rst) begin
      m_mode = 0; m_wait = 0; m_oe = 0; m_scl = 1; m_mrst = 0; m_led = 0; m_div = DV;
    end else begin
      case (m_mode)
        0: begin
          m_fail = 0;
          if (op_pend) begin
            if (op_done) begin m_fail = op_ackchk && op_nack; m_wait = 0; end
            else begin m_wait++; if (m_wait == T) m_fail = 1; end
          end else m_wait = 0;
          if (m_fail) begin
            m_mode = 1; m_led = 1; m_mrst = 1; m_div = 0; m_oe = 1; m_scl = 0;
            m_ticks = 0; m_pulses = 0;
          end
        end
        1: begin
          m_ticks++;
          if (m_ticks == PH) begin
            m_ticks = 0;
            if (!m_scl) m_scl = 1;
            else begin
              m_pulses++;
              if (sda_i || m_pulses == MP) m_mode = 3;
              else m_scl = 0;
            end
          end
        end
        3: begin m_oe = 0; m_settle = 0; m_mode = 2; end
        default: begin
          m_settle++;
          if (m_settle == ST) begin
            m_mode = 0; m_wait = 0; m_mrst = 0; m_led = 0; m_div = DV; m_done = 1;
          end
        end
      endcase
    end
  end

  int  n_rises = 0;
  bit  scl_prev = 1;

  always @(negedge clk) begin
    if (m_started) begin
      chk(tag, "scl_oe", scl_oe, m_oe);
      chk(tag, "scl_o", scl_o, m_scl);
      chk(tag, "mst_rst", mst_rst, m_mrst);
      chk(tag, "mst_div", mst_div, m_div);
      chk(tag, "err_led", err_led, m_led);
      chk(tag, "rec_done", rec_done, m_done);
    end
    if (scl_oe && scl_o && !scl_prev) n_rises++;
    scl_prev = scl_o;
  end

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  // len-1 waiting edges, completion sampled on the len-th edge
  task automatic run_op(int len, bit chkack, bit nack);
    @(negedge clk);
    op_pend = 1; op_done = 0; op_ackchk = chkack; op_nack = 0;
    ticks(len - 1);
    op_done = 1; op_nack = nack;
    ticks(1);
    op_pend = 0; op_done = 0; op_nack = 0; op_ackchk = 0;
  endtask

  task automatic wait_done(string t, int lim);
    bit seen = 0;
    for (int i = 0; i < lim && !seen; i++) begin
      @(negedge clk);
      if (rec_done) seen = 1;
    end
    chk(t, "rec_done_seen", seen, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    ticks(4);
    rst = 0;
    ticks(1);
    tag = "R1";
    chk(tag, "err_led_rst", err_led, 0);
    chk(tag, "mst_div_rst", mst_div, DV);
    chk(tag, "scl_oe_rst", scl_oe, 0);

    // R3: acknowledged byte and unchecked NACK; completion on the expiry edge
    tag = "R3";
    run_op(5, 1, 0);
    run_op(T, 0, 1);
    run_op(T, 1, 0);
    ticks(2);
    chk(tag, "err_led_clean", err_led, 0);

    // R9: chained operations under a continuous pending flag
    tag = "R9";
    @(negedge clk);
    op_pend = 1;
    for (int k = 0; k < 4; k++) begin
      ticks(T - 1);
      op_done = 1;
      ticks(1);
      op_done = 0;
    end
    op_pend = 0;
    ticks(2);
    chk(tag, "no_fail_chain", err_led, 0);

    // R2: timeout, SDA free so one pulse suffices (R5)
    tag = "R2";
    sda_i = 1; n_rises = 0;
    @(negedge clk);
    op_pend = 1;
    ticks(T);
    chk(tag, "led_after_timeout", err_led, 1);
    op_pend = 0;
    wait_done(tag, 200);
    chk("R5", "pulses_sda_high", n_rises, 1);

    // R6: stuck SDA, clocking capped
    tag = "R6";
    sda_i = 0; n_rises = 0;
    run_op(3, 1, 1);
    wait_done(tag, 400);
    chk(tag, "pulses_capped", n_rises, MP);
    sda_i = 1;

    // R5: SDA frees after the third pulse
    tag = "R5";
    sda_i = 0; n_rises = 0;
    run_op(2, 1, 1);
    while (n_rises < 3) @(negedge clk);
    sda_i = 1;
    wait_done(tag, 400);
    chk(tag, "pulses_early_stop", n_rises, 3);

    // R6 boundary: SDA frees on the last allowed pulse
    tag = "R6";
    sda_i = 0; n_rises = 0;
    run_op(2, 1, 1);
    while (n_rises < MP) @(negedge clk);
    sda_i = 1;
    wait_done(tag, 400);
    chk(tag, "pulses_last", n_rises, MP);

    // R8: op inputs toggled during recovery are ignored
    tag = "R8";
    n_rises = 0;
    run_op(2, 1, 1);
    op_pend = 1; op_done = 1; op_ackchk = 1; op_nack = 1;
    ticks(3);
    op_done = 0;
    ticks(3);
    op_pend = 0; op_ackchk = 0; op_nack = 0;
    wait_done(tag, 200);
    chk(tag, "single_pulse", n_rises, 1);
    ticks(T + 4);
    chk(tag, "stays_clean", err_led, 0);

    // R7: re-enable values after a recovery
    tag = "R7";
    chk(tag, "div_restored", mst_div, DV);
    chk(tag, "master_enabled", mst_rst, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule